// File: doc/BRIEF.md
# Four-Pin GPIO Port with Alternate-Function Pin Ownership

This block is a four-pin general-purpose I/O port. Software reaches it through a small register bus: a single-cycle write strobe and a combinational read path. Four registers are offered, each four bits wide. They hold the output data, the pin direction, the pullup enables and the slew selects. From these registers the port drives the pad controls for each pin: output value, output enable, pullup enable and slew select. Pad input levels pass through a two-flop synchronizer before they appear on data register reads.

Two alternate functions can take a pin away from the port. A debug/mode function owns pin 0 from reset until it pulses `dbg_release`. An oscillator owns pins 1 and 2 for as long as `osc_claim` is high. While a pin is owned, its pad output, output enable and pullup come from the owning function's inputs. Its slew select is forced low, and the port register bits for that pin have no effect on the pad.

Pin 0 ownership is held in a two-state machine:
- `OWN_DEBUG` is the reset state.
- The transition *release* (`dbg_release` high) moves it to `OWN_PORT`.
- `OWN_PORT` holds until the transition *reset* (`rst_n` low) returns it to `OWN_DEBUG`.
- While in `OWN_DEBUG` with no release, the machine stays in `OWN_DEBUG`.

Top module: `gpio_port_ovr`

## Requirements
- R1: Bits 7:4 of every register read back as zero, and writes to those bits have no effect.
- R2: A data register read (offset 0) returns, for each pin whose direction bit is 0, the pad input level two rising edges after it changes. For each pin whose direction bit is 1, it returns the stored data bit.
- R3: A data write stores all four bits whatever the direction. A port-controlled pin with direction 1 drives its stored bit on `pad_out` with `pad_oe` high. A pin with direction 0 has `pad_out` and `pad_oe` low.
- R4: Reset clears all four registers and leaves every port-controlled pin undriven with pullup off.
- R5: A port-controlled pin has `pad_pu` equal to its pullup bit only while its direction is 0, and `pad_slew` equal to its slew bit only while its direction is 1. Otherwise both are 0.
- R6: Pin 0 is owned by the debug function from reset until a cycle with `dbg_release` high; after that it is port-controlled until the next reset. While owned, `pad_out[0]`, `pad_oe[0]` and `pad_pu[0]` follow `dbg_out`, `dbg_oe` and `dbg_pu`, `pad_slew[0]` is 0, and `dbg_owned` is 1.
- R7: While `osc_claim` is high, pins 1 and 2 take `pad_out`, `pad_oe` and `pad_pu` from bits 0 and 1 of `osc_out`, `osc_oe` and `osc_pu`, and `pad_slew` is 0. When `osc_claim` drops, port control returns in the same cycle.
- R8: Register offsets: 0 data, 1 pullup enable, 2 slew select, 3 direction. Offsets 1 to 3 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pad_in | input | 4 | Pad input levels |
| pad_out | output | 4 | Pad output values |
| pad_oe | output | 4 | Pad output enables |
| pad_pu | output | 4 | Pad pullup enables |
| pad_slew | output | 4 | Pad slew selects |
| dbg_release | input | 1 | Debug function gives up pin 0 |
| dbg_out | input | 1 | Debug function output for pin 0 |
| dbg_oe | input | 1 | Debug function output enable for pin 0 |
| dbg_pu | input | 1 | Debug function pullup for pin 0 |
| dbg_owned | output | 1 | Pin 0 held by debug function |
| osc_claim | input | 1 | Oscillator owns pins 1 and 2 |
| osc_out | input | 2 | Oscillator outputs for pins 1 and 2 |
| osc_oe | input | 2 | Oscillator output enables for pins 1 and 2 |
| osc_pu | input | 2 | Oscillator pullups for pins 1 and 2 |

## Verification
The hardest case to reach is pin 0 under debug ownership while its port registers already hold values that would drive the pin. That state is needed to show the register bits are ignored. The stimulus writes direction, data, pullup and slew for pin 0 before any release. It then checks that the pad follows the debug inputs, and that the register values take effect only in the cycle after `dbg_release`. A second reset then shows ownership returning to the debug function.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_PULL = 2'd1,
        SEL_SLEW = 2'd2,
        SEL_DIR  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        OWN_DEBUG = 1'b0,
        OWN_PORT  = 1'b1
    } dbg_state_e;

    typedef struct packed {
        logic out;
        logic oe;
        logic pu;
    } fn_ctl_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned NPINS  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_async,
    output logic [NPINS-1:0] pin_sync
);
    logic [STAGES-1:0][NPINS-1:0] stage_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= pin_async;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_ovr_pkg::*;
#(
    parameter int unsigned NPINS  = 4,
    parameter int unsigned BUS_W  = 8,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [NPINS-1:0]  pin_sync,
    output logic [NPINS-1:0]  data_q,
    output logic [NPINS-1:0]  pull_q,
    output logic [NPINS-1:0]  slew_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [BUS_W-1:0]  rdata
);
    reg_sel_e         sel;
    logic [NPINS-1:0] wbits;

    assign sel   = reg_sel_e'(addr);
    assign wbits = wdata[NPINS-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            pull_q <= '0;
            slew_q <= '0;
            dir_q  <= '0;
        end else if (wr) begin
            unique case (sel)
                SEL_DATA: data_q <= wbits;
                SEL_PULL: pull_q <= wbits;
                SEL_SLEW: slew_q <= wbits;
                SEL_DIR:  dir_q  <= wbits;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_DATA: rdata[NPINS-1:0] = (dir_q & data_q) | (~dir_q & pin_sync);
            SEL_PULL: rdata[NPINS-1:0] = pull_q;
            SEL_SLEW: rdata[NPINS-1:0] = slew_q;
            SEL_DIR:  rdata[NPINS-1:0] = dir_q;
            default:  rdata = '0;
        endcase
    end

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_DIR) |=> (dir_q == $past(wbits)));          // R8
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr) |=> $stable(data_q));                                     // R3
endmodule

// File: rtl/gpio_own_fsm.sv
module gpio_own_fsm
    import gpio_ovr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic release_i,
    output logic owned_o
);
    dbg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OWN_DEBUG;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        owned_o = 1'b0;
        unique case (state_q)
            OWN_DEBUG: begin
                owned_o = 1'b1;
                if (release_i) state_d = OWN_PORT;
            end
            OWN_PORT: begin
                owned_o = 1'b0;
            end
            default: state_d = OWN_DEBUG;
        endcase
    end

    AST_DBG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OWN_PORT) |=> (state_q == OWN_PORT));               // R6
    AST_DBG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OWN_DEBUG && !release_i) |=> (state_q == OWN_DEBUG)); // R6
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_ovr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    owned_i,
    input  fn_ctl_t fn_i,
    input  logic    r_data,
    input  logic    r_dir,
    input  logic    r_pull,
    input  logic    r_slew,
    output logic    pad_out,
    output logic    pad_oe,
    output logic    pad_pu,
    output logic    pad_slew
);
    always_comb begin
        if (owned_i) begin
            pad_out  = fn_i.out;
            pad_oe   = fn_i.oe;
            pad_pu   = fn_i.pu;
            pad_slew = 1'b0;
        end else begin
            pad_out  = r_dir & r_data;
            pad_oe   = r_dir;
            pad_pu   = r_pull & ~r_dir;
            pad_slew = r_slew & r_dir;
        end
    end

    AST_PU_OFF_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!owned_i && pad_oe) |-> !pad_pu);                              // R5
    AST_SLEW_PORT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        pad_slew |-> (pad_oe && !owned_i));                             // R5
    AST_OWNED_NO_SLEW: assert property (@(posedge clk) disable iff (!rst_n)
        owned_i |-> !pad_slew);                                         // R6
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
    import gpio_ovr_pkg::*;
#(
    parameter int unsigned NPINS   = 4,
    parameter int unsigned BUS_W   = 8,
    parameter int unsigned DBG_PIN = 0,
    parameter int unsigned OSC_LO  = 1,
    parameter int unsigned OSC_N   = 2,
    parameter int unsigned SYNC_N  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_pu,
    output logic [NPINS-1:0] pad_slew,
    input  logic             dbg_release,
    input  logic             dbg_out,
    input  logic             dbg_oe,
    input  logic             dbg_pu,
    output logic             dbg_owned,
    input  logic             osc_claim,
    input  logic [OSC_N-1:0] osc_out,
    input  logic [OSC_N-1:0] osc_oe,
    input  logic [OSC_N-1:0] osc_pu
);
    localparam int unsigned OSC_HI = OSC_LO + OSC_N - 1;

    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] data_q, pull_q, slew_q, dir_q;
    logic             dbg_hold;

    gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_N)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pad_in),
        .pin_sync  (pin_sync)
    );

    gpio_regs #(.NPINS(NPINS), .BUS_W(BUS_W), .ADDR_W(2)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .data_q   (data_q),
        .pull_q   (pull_q),
        .slew_q   (slew_q),
        .dir_q    (dir_q),
        .rdata    (bus_rdata)
    );

    gpio_own_fsm u_own (
        .clk       (clk),
        .rst_n     (rst_n),
        .release_i (dbg_release),
        .owned_o   (dbg_hold)
    );

    assign dbg_owned = dbg_hold;

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_pin
            logic    owned;
            fn_ctl_t fn;

            if (p == DBG_PIN) begin : g_dbg
                assign owned = dbg_hold;
                assign fn    = '{out: dbg_out, oe: dbg_oe, pu: dbg_pu};
            end else if (p >= OSC_LO && p <= OSC_HI) begin : g_osc
                localparam int unsigned K = p - OSC_LO;
                assign owned = osc_claim;
                assign fn    = '{out: osc_out[K], oe: osc_oe[K], pu: osc_pu[K]};
            end else begin : g_plain
                assign owned = 1'b0;
                assign fn    = '{out: 1'b0, oe: 1'b0, pu: 1'b0};
            end

            gpio_pin_mux u_mux (
                .clk      (clk),
                .rst_n    (rst_n),
                .owned_i  (owned),
                .fn_i     (fn),
                .r_data   (data_q[p]),
                .r_dir    (dir_q[p]),
                .r_pull   (pull_q[p]),
                .r_slew   (slew_q[p]),
                .pad_out  (pad_out[p]),
                .pad_oe   (pad_oe[p]),
                .pad_pu   (pad_pu[p]),
                .pad_slew (pad_slew[p])
            );
        end
    endgenerate

    AST_RD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3) |=> (bus_addr != 2'd3 || bus_rdata[BUS_W-1:NPINS] == '0)); // R1
endmodule

// File: tb/gpio_port_ovr_tb.sv
module gpio_port_ovr_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [3:0] pad_in, pad_out, pad_oe, pad_pu, pad_slew;
    logic       dbg_release, dbg_out, dbg_oe, dbg_pu, dbg_owned;
    logic       osc_claim;
    logic [1:0] osc_out, osc_oe, osc_pu;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_ovr u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_slew(pad_slew),
        .dbg_release(dbg_release), .dbg_out(dbg_out), .dbg_oe(dbg_oe),
        .dbg_pu(dbg_pu), .dbg_owned(dbg_owned), .osc_claim(osc_claim),
        .osc_out(osc_out), .osc_oe(osc_oe), .osc_pu(osc_pu)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic release_dbg();
        @(negedge clk);
        dbg_release = 1'b1;
        @(negedge clk);
        dbg_release = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R4 register cleared", v, 8'h00);
        end
        chk("R4 no port drive", {4'h0, pad_oe}, 8'h00);
        chk("R4 pullups off", {4'h0, pad_pu}, 8'h00);
        chk("R6 owned after reset", {7'h0, dbg_owned}, 8'h01);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        wr(2'd1, 8'hF5); wr(2'd2, 8'h3A); wr(2'd3, 8'hC3);
        rd(2'd1, v); chk("R8 pullup readback, R1 high zero", v, 8'h05);
        rd(2'd2, v); chk("R8 slew readback", v, 8'h0A);
        rd(2'd3, v); chk("R8 dir readback", v, 8'h03);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'hF0);
        rd(2'd3, v); chk("R1 high bits ignore writes", v, 8'h00);
    endtask

    task automatic t_input_read();
        logic [7:0] v;
        @(negedge clk);
        pad_in = 4'b1010;
        @(negedge clk);
        rd(2'd0, v); chk("R2 one edge not yet visible", v, 8'h00);
        @(negedge clk);
        rd(2'd0, v); chk("R2 input level after two edges", v, 8'h0A);
    endtask

    task automatic t_output_read();
        logic [7:0] v;
        release_dbg();
        wr(2'd0, 8'hF5);
        wr(2'd3, 8'h03);
        rd(2'd0, v); chk("R2 mixed read", v, 8'h09);
        chk("R3 pad_out", {4'h0, pad_out}, 8'h01);
        chk("R3 pad_oe", {4'h0, pad_oe}, 8'h03);
        wr(2'd3, 8'h0F);
        chk("R3 stored on input pins", {4'h0, pad_out}, 8'h05);
        rd(2'd0, v); chk("R2 output read", v, 8'h05);
    endtask

    task automatic t_pull_slew();
        wr(2'd3, 8'h03);
        wr(2'd1, 8'h0F);
        wr(2'd2, 8'h0F);
        #1;
        chk("R5 pullup only inputs", {4'h0, pad_pu}, 8'h0C);
        chk("R5 slew only outputs", {4'h0, pad_slew}, 8'h03);
    endtask

    task automatic t_dbg();
        logic [7:0] v;
        do_reset();
        dbg_out = 1'b1; dbg_oe = 1'b0; dbg_pu = 1'b1;
        wr(2'd0, 8'h00); wr(2'd3, 8'h01); wr(2'd2, 8'h01); wr(2'd1, 8'h00);
        #1;
        chk("R6 owned pad_out", {7'h0, pad_out[0]}, 8'h01);
        chk("R6 owned pad_oe", {7'h0, pad_oe[0]}, 8'h00);
        chk("R6 owned pad_pu", {7'h0, pad_pu[0]}, 8'h01);
        chk("R6 owned no slew", {7'h0, pad_slew[0]}, 8'h00);
        @(negedge clk);
        dbg_release = 1'b1;
        #1;
        chk("R6 still owned in release cycle", {7'h0, pad_oe[0]}, 8'h00);
        @(negedge clk);
        dbg_release = 1'b0;
        chk("R6 released", {7'h0, dbg_owned}, 8'h00);
        chk("R6 port pad_oe", {7'h0, pad_oe[0]}, 8'h01);
        chk("R6 port pad_out", {7'h0, pad_out[0]}, 8'h00);
        chk("R6 port pad_pu", {7'h0, pad_pu[0]}, 8'h00);
        chk("R6 port slew", {7'h0, pad_slew[0]}, 8'h01);
        do_reset();
        chk("R6 owned again after reset", {7'h0, dbg_owned}, 8'h01);
        rd(2'd3, v); chk("R4 dir cleared by reset", v, 8'h00);
        rd(2'd2, v); chk("R4 slew cleared by reset", v, 8'h00);
        chk("R4 port pins undriven", {4'h0, pad_oe[3:1], 1'b0}, 8'h00);
    endtask

    task automatic t_osc();
        wr(2'd0, 8'h0F); wr(2'd3, 8'h0F); wr(2'd1, 8'h0F); wr(2'd2, 8'h0F);
        @(negedge clk);
        osc_claim = 1'b1; osc_out = 2'b01; osc_oe = 2'b10; osc_pu = 2'b11;
        #1;
        chk("R7 claimed pad_out", {5'h0, pad_out[3:1]}, 8'h05);
        chk("R7 claimed pad_oe", {5'h0, pad_oe[3:1]}, 8'h06);
        chk("R7 claimed pad_pu", {5'h0, pad_pu[3:1]}, 8'h03);
        chk("R7 claimed no slew", {5'h0, pad_slew[3:1]}, 8'h04);
        @(negedge clk);
        osc_claim = 1'b0;
        #1;
        chk("R7 returned pad_out", {5'h0, pad_out[3:1]}, 8'h07);
        chk("R7 returned pad_oe", {5'h0, pad_oe[3:1]}, 8'h07);
        chk("R7 returned pad_pu", {5'h0, pad_pu[3:1]}, 8'h00);
        chk("R7 returned slew", {5'h0, pad_slew[3:1]}, 8'h07);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        pad_in = '0; dbg_release = 1'b0; dbg_out = 1'b0; dbg_oe = 1'b0;
        dbg_pu = 1'b0; osc_claim = 1'b0; osc_out = '0; osc_oe = '0; osc_pu = '0;
        do_reset();
        t_reset_state();
        t_regmap();
        t_input_read();
        t_output_read();
        t_pull_slew();
        t_dbg();
        t_osc();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule